// File: doc/BRIEF.md
# Idle-Depth Cache Way and Core Power Sequencer

This controller turns a requested idle depth into an ordered series of power actions on one core and on the ways of a shared cache. Depth 0 is fully active. Depths below a core threshold keep everything powered. At the threshold or deeper, the controller first asks the core to save its architectural state into way 0, which is the reserved save area. Only after that does it remove core power. For each level beyond the threshold it then flushes and switches off more cache ways, one at a time, starting from the highest index.

When the requested depth becomes shallower, the controller undoes the work in reverse. It powers ways back on in ascending order, one per cycle. Once the core is allowed to run again, it powers the core and runs a restore handshake. The cache's write-back and the core's save and restore datapaths are outside this block. Each is represented by a request/acknowledge pair. A request stays high until its acknowledge arrives. A change in the requested depth takes effect only between way or core operations, never in the middle of one.

Top module: `way_gate_ctrl`

## Requirements
- R1: After reset, core_pwr is 1, ways_on equals NWAYS, every bit of way_pwr is 1, flush_req, save_req and restore_req are 0, and busy is 0.
- R2: For a requested depth below CORE_LVL (default 2), the core stays powered, all ways stay powered and no save handshake occurs.
- R3: core_pwr falls only in the cycle after save_req and save_ack were both high. A save is started whenever the depth is at least CORE_LVL and the core is powered.
- R4: At rest, ways_on equals NWAYS minus min((depth-CORE_LVL+1)*STEP, NWAYS-1) for depth >= CORE_LVL, and NWAYS otherwise. With defaults NWAYS=8 and STEP=2 that gives 8,8,6,4,2,1,1,1 for depths 0..7. way_pwr is a thermometer code in which bit i is 1 exactly when i < ways_on.
- R5: Ways are gated from the highest index down. While flush_req is high, flush_way equals ways_on-1, which is the highest powered way.
- R6: A way's enable drops only in the cycle after flush_req and flush_ack were both high, and by exactly one way. flush_req and flush_way hold steady until flush_ack arrives.
- R7: Way 0, the save area, stays powered whenever the core is unpowered.
- R8: On wake, ways come back one per cycle in ascending index order, before the core. core_pwr then rises together with restore_req, and restore_req stays high until restore_ack.
- R9: If the depth becomes shallower while a flush is outstanding, that flush still completes (exactly one way is gated), and the controller then reverses to the new target.
- R10: ways_on reports the count of powered ways. busy is 1 whenever a handshake is pending or the powered state does not yet match the requested depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idle_lvl | input | DW | Requested idle depth, 0 = active |
| flush_req | output | 1 | Flush and invalidate request for way flush_way |
| flush_way | output | log2(NWAYS) | Index of the way being flushed |
| flush_ack | input | 1 | Flush of flush_way complete |
| way_pwr | output | NWAYS | Per-way power enable |
| save_req | output | 1 | Ask the core to write its state into way 0 |
| save_ack | input | 1 | Core state saved |
| restore_req | output | 1 | Ask the core to reload its state from way 0 |
| restore_ack | input | 1 | Core state restored |
| core_pwr | output | 1 | Core power enable |
| ways_on | output | log2(NWAYS+1) | Number of powered ways |
| busy | output | 1 | Sequence in progress |

## Verification
A bad way counter shows up as soon as the next clock edge. It appears as a way_pwr pattern that is not a thermometer code, or as a flush_way that does not name the highest powered bit. A bad state register shows up within one handshake: the core loses power without a save acknowledge, or a way drops without a flush acknowledge. Ordering faults become visible when a sequence settles. They appear either as a settled ways_on that differs from the depth formula or as core_pwr rising before all target ways are back on. The bench sweeps every pair of start and end depths under several acknowledge latencies, so each of these symptoms is seen within a few hundred cycles.

// File: rtl/way_gate_ctrl.sv
module way_gate_ctrl #(
  parameter int NWAYS    = 8,
  parameter int STEP     = 2,
  parameter int CORE_LVL = 2,
  parameter int DW       = 3,
  localparam int WW = $clog2(NWAYS),
  localparam int CW = $clog2(NWAYS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] idle_lvl,
  output logic          flush_req,
  output logic [WW-1:0] flush_way,
  input  logic          flush_ack,
  output logic [NWAYS-1:0] way_pwr,
  output logic          save_req,
  input  logic          save_ack,
  output logic          restore_req,
  input  logic          restore_ack,
  output logic          core_pwr,
  output logic [CW-1:0] ways_on,
  output logic          busy
);

  typedef enum logic [1:0] {S_IDLE, S_SAVE, S_FLUSH, S_REST} st_t;
  st_t st;

  function automatic logic [CW-1:0] target_on(input logic [DW-1:0] lvl);
    int off;
    if (int'(lvl) < CORE_LVL) off = 0;
    else off = (int'(lvl) - CORE_LVL + 1) * STEP;
    if (off > NWAYS - 1) off = NWAYS - 1;
    return CW'(NWAYS - off);
  endfunction

  logic [CW-1:0] tgt;
  logic          deep;

  assign tgt         = target_on(idle_lvl);
  assign deep        = int'(idle_lvl) >= CORE_LVL;
  assign flush_req   = (st == S_FLUSH);
  assign save_req    = (st == S_SAVE);
  assign restore_req = (st == S_REST);
  assign flush_way   = WW'(ways_on - CW'(1));
  assign busy        = (st != S_IDLE) || (ways_on != tgt) || (core_pwr == deep);

  for (genvar i = 0; i < NWAYS; i++) begin : g_pwr
    assign way_pwr[i] = (ways_on > CW'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ways_on  <= CW'(NWAYS);
      core_pwr <= 1'b1;
    end else begin
      case (st)
        S_IDLE: begin
          if (deep && core_pwr)          st <= S_SAVE;
          else if (ways_on > tgt)        st <= S_FLUSH;
          else if (ways_on < tgt)        ways_on <= ways_on + CW'(1);
          else if (!deep && !core_pwr) begin
            core_pwr <= 1'b1;
            st       <= S_REST;
          end
        end
        S_SAVE: if (save_ack) begin
          core_pwr <= 1'b0;
          st       <= S_IDLE;
        end
        S_FLUSH: if (flush_ack) begin
          ways_on <= ways_on - CW'(1);
          st      <= S_IDLE;
        end
        S_REST: if (restore_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/way_gate_ctrl_chk.sv
module way_gate_ctrl_chk #(
  parameter int NWAYS = 8,
  parameter int WW    = 3,
  parameter int CW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush_req,
  input logic [WW-1:0]    flush_way,
  input logic             flush_ack,
  input logic [NWAYS-1:0] way_pwr,
  input logic             save_req,
  input logic             save_ack,
  input logic             restore_req,
  input logic             restore_ack,
  input logic             core_pwr,
  input logic [CW-1:0]    ways_on,
  input logic             busy
);

  // R3
  core_off_after_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_pwr) |-> $past(save_req && save_ack));

  // R6
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req && !flush_ack |=> flush_req && $stable(flush_way));

  // R6
  way_drop_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ways_on < $past(ways_on)) |-> ($past(flush_req && flush_ack) && ways_on == $past(ways_on) - CW'(1)));

  // R5
  flush_top_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> ((way_pwr >> flush_way) == NWAYS'(1)));

  // R7
  save_way_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_pwr |-> way_pwr[0]);

  // R8
  core_up_with_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_pwr) |-> restore_req);

  // R8
  restore_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore_req && !restore_ack |=> restore_req && core_pwr);

  // R8
  way_up_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ways_on > $past(ways_on)) |-> (ways_on == $past(ways_on) + CW'(1) && !$past(core_pwr && restore_req)));

  // R10
  busy_in_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req || save_req || restore_req) |-> busy);

  // R10
  one_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flush_req, save_req, restore_req}));

endmodule

bind way_gate_ctrl way_gate_ctrl_chk #(.NWAYS(NWAYS), .WW(WW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush_req(flush_req), .flush_way(flush_way),
  .flush_ack(flush_ack), .way_pwr(way_pwr), .save_req(save_req), .save_ack(save_ack),
  .restore_req(restore_req), .restore_ack(restore_ack), .core_pwr(core_pwr),
  .ways_on(ways_on), .busy(busy));

// File: tb/way_gate_ctrl_tb.sv
`timescale 1ns/1ps
module way_gate_ctrl_tb;
  localparam int NWAYS = 8;

  logic clk = 0, rst_n = 0;
  logic [2:0] idle_lvl = 0;
  logic flush_req, flush_ack = 0, save_req, save_ack = 0, restore_req, restore_ack = 0;
  logic [2:0] flush_way;
  logic [NWAYS-1:0] way_pwr;
  logic core_pwr, busy;
  logic [3:0] ways_on;

  int total = 0, bad = 0, lat = 0;
  int nflush = 0, nsave = 0, nrest = 0;
  bit pend_save = 0, prev_core = 1, seen_fall_ok = 1;

  always #4 clk = ~clk;

  way_gate_ctrl u_dut (.clk, .rst_n, .idle_lvl, .flush_req, .flush_way, .flush_ack,
    .way_pwr, .save_req, .save_ack, .restore_req, .restore_ack, .core_pwr, .ways_on, .busy);

  function automatic int exp_on(input int d);
    int v;
    if (d < 2) return NWAYS;
    v = NWAYS - (d - 1) * 2;
    return (v < 1) ? 1 : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  // handshake responder and port monitor
  initial begin
    int fc = 0, sc = 0, rc = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        chk(way_pwr == NWAYS'((1 << ways_on) - 1), "R4 thermometer", int'(way_pwr), (1 << ways_on) - 1);
        if (!core_pwr) chk(way_pwr[0], "R7 save way powered", int'(way_pwr[0]), 1);
        if (prev_core && !core_pwr) begin
          chk(pend_save, "R3 core off after save", int'(pend_save), 1);
          pend_save = 0;
        end
        if (!prev_core && core_pwr) begin
          chk(restore_req, "R8 restore with core up", int'(restore_req), 1);
          chk(int'(ways_on) == exp_on(int'(idle_lvl)), "R8 ways before core", int'(ways_on), exp_on(int'(idle_lvl)));
        end
        prev_core = core_pwr;
      end
      if (flush_req) begin
        if (fc >= lat && !flush_ack) begin
          chk(int'(flush_way) == int'(ways_on) - 1, "R5 top way flushed", int'(flush_way), int'(ways_on) - 1);
          chk(way_pwr[flush_way], "R6 way powered during flush", int'(way_pwr[flush_way]), 1);
          nflush++;
        end
        flush_ack = (fc >= lat);
        fc++;
      end else begin fc = 0; flush_ack = 0; end
      if (save_req) begin
        if (sc >= lat && !save_ack) begin nsave++; pend_save = 1; end
        save_ack = (sc >= lat);
        sc++;
      end else begin sc = 0; save_ack = 0; end
      if (restore_req) begin
        if (rc >= lat && !restore_ack) nrest++;
        restore_ack = (rc >= lat);
        rc++;
      end else begin rc = 0; restore_ack = 0; end
    end
  end

  task automatic settle(input string req);
    int n = 0;
    @(negedge clk); #1;
    while (busy && n < 400) begin @(negedge clk); #1; n++; end
    chk(!busy, req, int'(busy), 0);
  endtask

  task automatic goto(input int d, input string req);
    @(negedge clk);
    idle_lvl = 3'(d);
    settle(req);
    chk(int'(ways_on) == exp_on(d), req, int'(ways_on), exp_on(d));
    chk(core_pwr == (d < 2), req, int'(core_pwr), int'(d < 2));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0, f0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1
    chk(ways_on == 4'(NWAYS) && way_pwr == '1, "R1 ways after reset", int'(ways_on), NWAYS);
    chk(core_pwr && !flush_req && !save_req && !restore_req && !busy, "R1 idle after reset",
        int'({core_pwr, flush_req, save_req, restore_req, busy}), 16);

    // R2 shallow depth
    s0 = nsave;
    goto(1, "R2 shallow depth");
    chk(nsave == s0, "R2 no save when shallow", nsave - s0, 0);

    // R10 busy rises on a deeper request
    @(negedge clk);
    idle_lvl = 3'd3; #1;
    chk(busy, "R10 busy on new depth", int'(busy), 1);
    settle("R10 settles");
    chk(int'(ways_on) == 4, "R10 ways_on count", int'(ways_on), 4);
    goto(0, "R8 wake to active");

    // R9 wake during a pending flush
    lat = 4;
    s0 = nsave; f0 = nflush; r0 = nrest;
    @(negedge clk);
    idle_lvl = 3'd7;
    while (!flush_req) @(negedge clk);
    idle_lvl = 3'd0;
    settle("R9 reversal settles");
    chk(nflush - f0 == 1, "R9 pending flush completes once", nflush - f0, 1);
    chk(nsave - s0 == 1 && nrest - r0 == 1, "R9 save and restore once", nrest - r0, 1);
    chk(int'(ways_on) == NWAYS && core_pwr, "R9 back to active", int'(ways_on), NWAYS);

    // R3 R4 R5 R6 R8: sweep every start/end depth pair with varied latency
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        lat = (a + b) % 3;
        goto(a, "R4 start depth");
        f0 = nflush;
        goto(b, "R4 end depth");
        if (b > a) chk(nflush - f0 == exp_on(a) - exp_on(b), "R6 one flush per gated way",
                       nflush - f0, exp_on(a) - exp_on(b));
        else chk(nflush == f0, "R8 no flush on wake", nflush - f0, 0);
      end
    end
    goto(0, "R8 final wake");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule